// File: doc/BRIEF.md
# Byte-Wide Memory Boot Loader

After reset this block copies a program image from a slow external memory that is eight bits wide into on-chip 24-bit program RAM. When the copy is complete it tells the core where to begin executing. It drives an 18-bit external byte address and takes each byte from the low eight data lines only. Each access is held for a fixed number of wait states before the byte is sampled.

The image starts with a header. The header holds a 24-bit word count and then a 24-bit load address. After the header come the program words, three bytes each. Every 24-bit value is sent low byte first, then the middle byte, then the high byte. The words go to consecutive RAM locations, starting at the load address. When the last word has been written, a one-cycle done pulse is raised. The load address appears on the entry output in that same cycle. The loader is idle after reset and starts work only when its start input is asserted.

Top module: `boot_byte_loader`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `pram_we_o` and `ext_rd_o` are all 0. The loader stays idle until `start_i` is sampled high, and `busy_o` rises only in the cycle after that sample.
- R2: The first external read is at address 0. Each later read is at the previous address plus one.
- R3: Each external address is held for WAIT_STATES+1 clock cycles (32 by default). The byte is sampled in the last of those cycles, so every byte costs 32 cycles.
- R4: Only data bits 7:0 are used. Bits above 7 have no effect on anything the loader writes or reports.
- R5: The first three bytes give the word count and the next three give the load address. Each is assembled as byte0 = bits 7:0, byte1 = bits 15:8, byte2 = bits 23:16.
- R6: Each program word is assembled from three bytes in the same low-to-high order. Word i is written with `pram_we_o` to address load+i, taken modulo 2^24.
- R7: `done_o` is a one-cycle pulse, and `entry_addr_o` equals the load address while it is high. For a non-zero count, the pulse shares its cycle with the last RAM write. `busy_o` is 0 in the done cycle.
- R8: A word count of zero produces no RAM write. In that case `done_o` rises 6*32 cycles after the start edge, right after the header. In general it rises (6+3N)*32 cycles after the start edge.
- R9: `busy_o` and `ext_rd_o` stay high from the first cycle after start until the done cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin loading (sampled while idle) |
| ext_addr_o | output | 18 | External byte address |
| ext_rd_o | output | 1 | External read active |
| ext_data_i | input | 24 | External data bus; only bits 7:0 are used |
| pram_we_o | output | 1 | Program RAM write strobe |
| pram_addr_o | output | 24 | Program RAM write address |
| pram_wdata_o | output | 24 | Program RAM write data |
| busy_o | output | 1 | Loader active |
| done_o | output | 1 | One-cycle completion pulse |
| entry_addr_o | output | 24 | Execution entry address, valid with done_o |

## Verification
The write of the last program word and the completion pulse land on the same clock edge. In that cycle `busy_o` has already dropped while `pram_we_o` is still high. The bench provokes this with directed one-word and eight-word images, with a load address that wraps past 0xFFFFFF, and with random images of 0 to 8 words whose upper data lines carry random noise. In the done cycle it requires the write strobe to be high exactly when the count is non-zero, the number of writes seen to equal the count, the entry address to equal the load address, and the cycle number to equal (6+3N)*32 after the start edge.

// File: rtl/boot_loader_pkg.sv
// Shared types for the byte-wide boot loader.
package boot_loader_pkg;
    // Loader phase: idle, reading the count, reading the load address, copying words
    typedef enum logic [1:0] {
        LD_IDLE   = 2'd0,
        LD_COUNT  = 2'd1,
        LD_ORIGIN = 2'd2,
        LD_IMAGE  = 2'd3
    } ld_state_e;
endpackage

// File: rtl/boot_wait_timer.sv
// Wait-state timer. While run_i is high it counts cycles and fires
// sample_o in the cycle after WAIT_STATES full wait cycles. Then it restarts.
// Assumes run_i is low between loads, which clears the count.
module boot_wait_timer #(
    parameter int WAIT_STATES = 31
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sample_o
);
    localparam int CW = $clog2(WAIT_STATES + 2);
    localparam logic [CW-1:0] LAST = CW'(WAIT_STATES);

    logic [CW-1:0] cnt_q;

    assign sample_o = run_i && (cnt_q == LAST);

    // Advance the per-access cycle count, wrapping after the sample cycle
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (sample_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/boot_byte_packer.sv
// Byte packer. It gathers BYTES_PER_WORD sampled bytes, low byte first.
// word_ready_o fires in the cycle the final byte is sampled, and word_o
// then holds the full word. clear_i returns the packer to the first lane.
module boot_byte_packer #(
    parameter int BYTE_W = 8,
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              sample_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              word_ready_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int NB = WORD_W / BYTE_W;
    localparam int LW = (NB > 1) ? $clog2(NB) : 1;
    localparam logic [LW-1:0] LAST_LANE = LW'(NB - 1);

    logic [LW-1:0]              lane_q;
    logic [WORD_W-BYTE_W-1:0]   low_q;

    assign word_ready_o = sample_i && (lane_q == LAST_LANE);
    assign word_o       = {byte_i, low_q};

    // Track which byte lane the next sample fills
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            lane_q <= '0;
        end else if (sample_i) begin
            lane_q <= (lane_q == LAST_LANE) ? '0 : lane_q + 1'b1;
        end
    end

    // Hold the lower lanes of the word being assembled
    generate
        for (genvar g = 0; g < NB - 1; g++) begin : g_lane
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    low_q[g*BYTE_W +: BYTE_W] <= '0;
                end else if (sample_i && lane_q == LW'(g)) begin
                    low_q[g*BYTE_W +: BYTE_W] <= byte_i;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/boot_seq_ctrl.sv
// Sequencer. It walks through the count, load-address and image phases,
// steps the external byte address on every sample, registers RAM writes,
// and raises done with the entry address when the last word lands.
// Assumes word_ready_i is a one-cycle strobe aligned with sample_i.
module boot_seq_ctrl
    import boot_loader_pkg::*;
#(
    parameter int EXT_AW = 18,
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              sample_i,
    input  logic              word_ready_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              busy_o,
    output logic [EXT_AW-1:0] ext_addr_o,
    output logic              pram_we_o,
    output logic [WORD_W-1:0] pram_addr_o,
    output logic [WORD_W-1:0] pram_wdata_o,
    output logic              done_o,
    output logic [WORD_W-1:0] entry_addr_o
);
    ld_state_e          state_q;
    logic [EXT_AW-1:0]  addr_q;
    logic [WORD_W-1:0]  remain_q;
    logic [WORD_W-1:0]  origin_q;
    logic [WORD_W-1:0]  wptr_q;

    assign busy_o       = (state_q != LD_IDLE);
    assign ext_addr_o   = addr_q;
    assign entry_addr_o = origin_q;

    // External byte address: restart at zero on start, step after each sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (state_q == LD_IDLE && start_i) begin
            addr_q <= '0;
        end else if (sample_i) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    // Phase control, header capture, word counting and write pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= LD_IDLE;
            remain_q     <= '0;
            origin_q     <= '0;
            wptr_q       <= '0;
            pram_we_o    <= 1'b0;
            pram_addr_o  <= '0;
            pram_wdata_o <= '0;
            done_o       <= 1'b0;
        end else begin
            pram_we_o <= 1'b0;
            done_o    <= 1'b0;
            case (state_q)
                LD_IDLE: begin
                    if (start_i) state_q <= LD_COUNT;
                end
                LD_COUNT: begin
                    if (word_ready_i) begin
                        remain_q <= word_i;
                        state_q  <= LD_ORIGIN;
                    end
                end
                LD_ORIGIN: begin
                    if (word_ready_i) begin
                        origin_q <= word_i;
                        wptr_q   <= word_i;
                        if (remain_q == '0) begin
                            done_o  <= 1'b1;
                            state_q <= LD_IDLE;
                        end else begin
                            state_q <= LD_IMAGE;
                        end
                    end
                end
                LD_IMAGE: begin
                    if (word_ready_i) begin
                        pram_we_o    <= 1'b1;
                        pram_addr_o  <= wptr_q;
                        pram_wdata_o <= word_i;
                        wptr_q       <= wptr_q + 1'b1;
                        remain_q     <= remain_q - 1'b1;
                        if (remain_q == WORD_W'(1)) begin
                            done_o  <= 1'b1;
                            state_q <= LD_IDLE;
                        end
                    end
                end
                default: state_q <= LD_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/boot_byte_loader.sv
// Top of the byte-wide boot loader. It ties the wait timer, byte packer
// and sequencer together. Only the low BYTE_W data lines feed the packer.
// Assumes the external memory returns stable data by the sample cycle.
module boot_byte_loader #(
    parameter int EXT_AW      = 18,
    parameter int EXT_DW      = 24,
    parameter int BYTE_W      = 8,
    parameter int WORD_W      = 24,
    parameter int WAIT_STATES = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic [EXT_AW-1:0] ext_addr_o,
    output logic              ext_rd_o,
    input  logic [EXT_DW-1:0] ext_data_i,
    output logic              pram_we_o,
    output logic [WORD_W-1:0] pram_addr_o,
    output logic [WORD_W-1:0] pram_wdata_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [WORD_W-1:0] entry_addr_o
);
    logic              sample;
    logic              word_ready;
    logic [WORD_W-1:0] word;
    logic              busy;
    logic              unused_hi;

    assign unused_hi = ^ext_data_i[EXT_DW-1:BYTE_W];
    assign busy_o    = busy;
    assign ext_rd_o  = busy;

    boot_wait_timer #(.WAIT_STATES(WAIT_STATES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (busy),
        .sample_o (sample)
    );

    boot_byte_packer #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_packer (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (!busy),
        .sample_i     (sample),
        .byte_i       (ext_data_i[BYTE_W-1:0]),
        .word_ready_o (word_ready),
        .word_o       (word)
    );

    boot_seq_ctrl #(.EXT_AW(EXT_AW), .WORD_W(WORD_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .sample_i     (sample),
        .word_ready_i (word_ready),
        .word_i       (word),
        .busy_o       (busy),
        .ext_addr_o   (ext_addr_o),
        .pram_we_o    (pram_we_o),
        .pram_addr_o  (pram_addr_o),
        .pram_wdata_o (pram_wdata_o),
        .done_o       (done_o),
        .entry_addr_o (entry_addr_o)
    );
endmodule

// File: rtl/boot_byte_loader_chk.sv
// Protocol checker for boot_byte_loader, attached with bind.
// A cycle counter measures how long each external address is held.
module boot_byte_loader_chk #(
    parameter int EXT_AW      = 18,
    parameter int WAIT_STATES = 31
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [EXT_AW-1:0] ext_addr_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              pram_we_o
);
    localparam int HW = $clog2(WAIT_STATES + 3) + 1;

    logic [HW-1:0]     hold_q;
    logic [EXT_AW-1:0] prev_addr_q;
    logic              prev_busy_q;
    logic              moved;

    assign moved = busy_o && prev_busy_q && (ext_addr_o != prev_addr_q);

    // Count the cycles the current external address has been held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q      <= '0;
            prev_addr_q <= '0;
            prev_busy_q <= 1'b0;
        end else begin
            prev_addr_q <= ext_addr_o;
            prev_busy_q <= busy_o;
            if (!busy_o)    hold_q <= '0;
            else if (moved) hold_q <= HW'(1);
            else            hold_q <= hold_q + 1'b1;
        end
    end

    // R3
    hold_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        moved |-> hold_q == HW'(WAIT_STATES + 1));

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        moved |-> ext_addr_o == prev_addr_q + 1'b1);

    // R2
    first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ext_addr_o == '0);

    // R1
    start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && $past(busy_o));

    // R6
    write_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pram_we_o |-> $past(busy_o));
endmodule

bind boot_byte_loader boot_byte_loader_chk #(
    .EXT_AW      (EXT_AW),
    .WAIT_STATES (WAIT_STATES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .ext_addr_o (ext_addr_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .pram_we_o  (pram_we_o)
);

// File: tb/boot_byte_loader_test.sv
// Bench: directed corner images plus seeded random images, checked
// against expectations built from the requirements.
module boot_byte_loader_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [17:0] ext_addr_o;
    logic        ext_rd_o;
    logic [23:0] ext_data_i;
    logic        pram_we_o;
    logic [23:0] pram_addr_o;
    logic [23:0] pram_wdata_o;
    logic        busy_o;
    logic        done_o;
    logic [23:0] entry_addr_o;

    logic [7:0]  mem [0:63];
    logic [15:0] noise = 16'h0;
    logic [23:0] exp_word [0:15];
    int          n_tests = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    always_comb ext_data_i = {noise, mem[ext_addr_o[5:0]]};

    boot_byte_loader uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .ext_addr_o(ext_addr_o), .ext_rd_o(ext_rd_o), .ext_data_i(ext_data_i),
        .pram_we_o(pram_we_o), .pram_addr_o(pram_addr_o), .pram_wdata_o(pram_wdata_o),
        .busy_o(busy_o), .done_o(done_o), .entry_addr_o(entry_addr_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int load_cycles(input int words);
        return 32 * (6 + 3 * words);
    endfunction

    // Place a header and image in the byte memory, low byte first
    task automatic build_image(input int words, input logic [23:0] org);
        for (int i = 0; i < 64; i++) mem[i] = 8'($urandom);
        for (int b = 0; b < 3; b++) begin
            mem[b]     = 8'(words >> (8 * b));
            mem[3 + b] = org[8*b +: 8];
        end
        for (int w = 0; w < words; w++) begin
            exp_word[w] = 24'($urandom);
            for (int b = 0; b < 3; b++) mem[6 + 3*w + b] = exp_word[w][8*b +: 8];
        end
    endtask

    task automatic run_image(input int words, input logic [23:0] org);
        int cyc;
        int widx;
        int limit;
        build_image(words, org);
        limit = load_cycles(words) + 40;
        @(negedge clk);
        start_i = 1'b1;
        cyc = 0;
        widx = 0;
        do begin
            @(negedge clk);
            start_i = 1'b0;
            noise = 16'($urandom);
            cyc++;
            if (pram_we_o) begin
                // R6 consecutive addresses and low-first assembly; R4 noise ignored
                check(pram_addr_o == 24'(org + widx), "R6 addr", 32'(pram_addr_o), 32'(24'(org + widx)));
                check(widx < words && pram_wdata_o == exp_word[widx], "R4/R6 data",
                      32'(pram_wdata_o), (widx < words) ? 32'(exp_word[widx]) : 32'hDEAD);
                widx++;
            end
            if (!done_o) begin
                if (cyc % 32 == 1 || cyc % 32 == 0) begin
                    // R9 busy and read active; R2/R3 address sequence and hold time
                    check(busy_o && ext_rd_o, "R9 busy", 32'({busy_o, ext_rd_o}), 32'h3);
                    check(ext_addr_o == 18'((cyc - 1) / 32), "R2/R3 ext addr",
                          32'(ext_addr_o), 32'((cyc - 1) / 32));
                end
            end
        end while (!done_o && cyc < limit);
        // R8 completion timing counted from the start edge
        check(cyc == load_cycles(words) + 1, "R8 done timing", 32'(cyc), 32'(load_cycles(words) + 1));
        // R5/R7 entry address equals parsed load address
        check(entry_addr_o == org, "R5/R7 entry", 32'(entry_addr_o), 32'(org));
        // R7 last write shares the done cycle, busy already low
        check(pram_we_o == (words > 0), "R7 write with done", 32'(pram_we_o), 32'(words > 0));
        check(!busy_o, "R7 busy low at done", 32'(busy_o), 32'h0);
        // R5/R6/R8 number of words written equals the count
        check(widx == words, "R5/R8 write count", 32'(widx), 32'(words));
        @(negedge clk);
        check(!done_o && !pram_we_o, "R7 single pulse", 32'({done_o, pram_we_o}), 32'h0);
    endtask

    initial begin
        void'($urandom(32'd1357));
        for (int i = 0; i < 64; i++) mem[i] = 8'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy_o && !done_o && !pram_we_o && !ext_rd_o, "R1 reset",
              32'({busy_o, done_o, pram_we_o, ext_rd_o}), 32'h0);
        repeat (50) @(negedge clk);
        // R1 idle without start
        check(!busy_o && !done_o, "R1 idle hold", 32'({busy_o, done_o}), 32'h0);

        run_image(0, 24'h00ABCD);     // R8 zero count
        run_image(1, 24'h001000);     // single word
        run_image(8, 24'h123456);     // longest image
        run_image(3, 24'hFFFFFE);     // R6 wrap past top of address space
        for (int r = 0; r < 6; r++) begin
            run_image(int'($urandom_range(0, 8)), 24'($urandom));
        end
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 32'h0, 32'h1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule